// File: doc/BRIEF.md
# Boot Page Translation and Address Window Decoder

This block sits on the physical address path of a multicore processor during boot. Each request address first passes a boot-page remapper. A single 4KB page at the very top of the low 4GB (0x0_FFFF_F000 to 0x0_FFFF_FFFF) can be redirected to any 4KB page below 4GB, which lets secondary cores fetch their first instructions from memory instead of the boot device. The translated address is then decoded against a bank of programmable address windows. Each window has an enable, a size-aligned base, a power-of-two size and a target ID. A fixed 8MB boot window (0x0_FF80_0000 to 0x0_FFFF_FFFF) routes to the boot device only when no programmed window matches.

Software programs the remapper and the windows through two write ports. Each port applies to requests accepted on the cycle after the write. Every request returns its translated address, the selected target ID and a miss flag exactly one cycle later. The response stage is a two-state machine. RS_IDLE means no result is on the outputs. RS_RESULT means a registered result is on the outputs. The transition into RS_RESULT (from either state) is taken on any cycle with `req_valid` high. The transition into RS_IDLE (from either state) is taken on any cycle with `req_valid` low. Reset forces RS_IDLE.

Top module: `boot_xlat_decoder`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high, and low otherwise. `rsp_addr`, `rsp_tgt` and `rsp_miss` describe that request.
- R2: With remapping disabled, an address in the boot page (bits 35:12 equal 0x0FFFFF) is returned unchanged.
- R3: With remapping enabled, a boot-page address is returned as {4'h0, page[19:0], offset[11:0]}, keeping the low 12 bits. Any address outside the boot page, including every address whose bits 35:32 are nonzero, is returned unchanged.
- R4: A translated address within 0x0_FF80_0000..0x0_FFFF_FFFF that no enabled window covers returns target BOOT_TGT with `rsp_miss` low.
- R5: An enabled window covers the addresses A with base_aligned <= A < base_aligned + 2^size. The base is written as a 24-bit page number (address bits 35:12). The size code is log2 of the window size in bytes, from 12 to 32; codes below 12 act as 12 and codes above 32 act as 32. base_aligned is the base address with bits below the size cleared. A covered address returns that window's target with `rsp_miss` low.
- R6: A programmed window that covers an address inside the boot window takes precedence over the boot window.
- R7: When several enabled windows cover an address, the lowest-numbered one supplies the target.
- R8: Window matching uses the translated address. A remapped boot-page access lands on a target only if its new address is covered by a window or by the boot window.
- R9: An address covered by no enabled window and outside the boot window returns `rsp_miss` high and `rsp_tgt` zero.
- R10: A register write takes effect for requests accepted on the next cycle and later. A request in the same cycle as a write uses the old settings.
- R11: After reset, `rsp_valid` is low, remapping is disabled and every window is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_we | input | 1 | Write strobe for the boot-page remap register |
| xlat_en_wr | input | 1 | Remap enable value to write |
| xlat_page_wr | input | 20 | Destination page number (address bits 31:12) to write |
| win_we | input | 1 | Write strobe for one window register |
| win_idx | input | IDX_W (3) | Window number to write |
| win_en_wr | input | 1 | Window enable value |
| win_base_wr | input | 24 | Window base page number (address bits 35:12) |
| win_size_wr | input | 6 | Window size code, log2 of bytes |
| win_tgt_wr | input | TGT_W (5) | Window target ID |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 36 | Request physical address |
| rsp_valid | output | 1 | Result valid, one cycle after a request |
| rsp_addr | output | 36 | Translated address |
| rsp_tgt | output | TGT_W (5) | Selected target ID |
| rsp_miss | output | 1 | No window and no boot window matched |

## Verification
The hardest situation to reach is a remapped boot-page access whose routing depends on three things at once: the remap setting, the programmed windows and the same-cycle write ordering. To get there, the stimulus writes the remap register in the same cycle as a boot-page request, which must still see the old mapping. It then repeats the request with no window covering the new page, which must miss. Finally it programs an overlapping pair of windows, one with unaligned base bits, and disables the lower-numbered window to expose the other. A behavioural model in the bench mirrors every write and predicts each response in the cycle it appears.

// File: rtl/boot_xlat_pkg.sv
package boot_xlat_pkg;

    localparam int PA_W        = 36;             // physical address width
    localparam int OFS_W       = 12;             // 4KB page offset
    localparam int PN_W        = PA_W - OFS_W;   // page number width
    localparam int LOW_W       = 32;             // remap target range (4GB)
    localparam int XPN_W       = LOW_W - OFS_W;  // remap page number width
    localparam int SZ_W        = 6;              // size code width
    localparam int SZ_MIN      = 12;
    localparam int SZ_MAX      = 32;
    localparam int BOOTWIN_LOG = 23;             // 8MB fallback window

    localparam logic [PA_W-1:0] BOOT_PAGE_ADDR = 36'h0_FFFF_F000;
    localparam logic [PA_W-1:0] BOOT_WIN_ADDR  = 36'h0_FF80_0000;

    typedef struct packed {
        logic            en;
        logic [PN_W-1:0] base;
        logic [SZ_W-1:0] size;
    } win_geom_t;

    function automatic logic [SZ_W-1:0] clamp_size(input logic [SZ_W-1:0] s);
        if (s < SZ_W'(SZ_MIN))      return SZ_W'(SZ_MIN);
        else if (s > SZ_W'(SZ_MAX)) return SZ_W'(SZ_MAX);
        else                        return s;
    endfunction

endpackage

// File: rtl/boot_page_remap.sv
module boot_page_remap
    import boot_xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             en_wr,
    input  logic [XPN_W-1:0] page_wr,
    input  logic [PA_W-1:0]  addr_in,
    output logic [PA_W-1:0]  addr_out
);

    logic             en_q;
    logic [XPN_W-1:0] page_q;
    logic             in_page;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            page_q <= '0;
        end else if (we) begin
            en_q   <= en_wr;
            page_q <= page_wr;
        end
    end

    always_comb begin
        in_page = (addr_in[PA_W-1:OFS_W] == BOOT_PAGE_ADDR[PA_W-1:OFS_W]);
        if (en_q && in_page)
            addr_out = {{(PA_W-LOW_W){1'b0}}, page_q, addr_in[OFS_W-1:0]};
        else
            addr_out = addr_in;
    end

endmodule

// File: rtl/win_match_array.sv
module win_match_array
    import boot_xlat_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int TGT_W   = 5,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
)(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [IDX_W-1:0]               idx,
    input  logic                           en_wr,
    input  logic [PN_W-1:0]                base_wr,
    input  logic [SZ_W-1:0]                size_wr,
    input  logic [TGT_W-1:0]               tgt_wr,
    input  logic [PA_W-1:0]                addr,
    output logic [NUM_WIN-1:0]             hit,
    output logic [NUM_WIN-1:0][TGT_W-1:0]  tgt
);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        win_geom_t        geom_q;
        logic [TGT_W-1:0] tgt_q;
        logic [PA_W-1:0]  mask;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                geom_q <= '0;
                tgt_q  <= '0;
            end else if (we && idx == IDX_W'(g)) begin
                geom_q.en   <= en_wr;
                geom_q.base <= base_wr;
                geom_q.size <= clamp_size(size_wr);
                tgt_q       <= tgt_wr;
            end
        end

        always_comb begin
            mask   = {PA_W{1'b1}} << geom_q.size;
            hit[g] = geom_q.en &&
                     (((addr ^ {geom_q.base, {OFS_W{1'b0}}}) & mask) == '0);
            tgt[g] = tgt_q;
        end
    end

endmodule

// File: rtl/win_prio_sel.sv
module win_prio_sel
    import boot_xlat_pkg::*;
#(
    parameter int          NUM_WIN  = 8,
    parameter int          TGT_W    = 5,
    parameter int unsigned BOOT_TGT = 30
)(
    input  logic [NUM_WIN-1:0]            hit,
    input  logic [NUM_WIN-1:0][TGT_W-1:0] tgt,
    input  logic [PA_W-1:0]               addr,
    output logic [TGT_W-1:0]              sel_tgt,
    output logic                          sel_miss
);

    logic any_hit;
    logic in_boot_win;

    always_comb begin
        any_hit = 1'b0;
        sel_tgt = '0;
        // walk downward so the lowest-numbered hit is applied last
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any_hit = 1'b1;
                sel_tgt = tgt[i];
            end
        end
        in_boot_win = (addr[PA_W-1:BOOTWIN_LOG] == BOOT_WIN_ADDR[PA_W-1:BOOTWIN_LOG]);
        sel_miss    = 1'b0;
        if (!any_hit) begin
            if (in_boot_win) begin
                sel_tgt = TGT_W'(BOOT_TGT);
            end else begin
                sel_tgt  = '0;
                sel_miss = 1'b1;
            end
        end
    end

endmodule

// File: rtl/boot_xlat_decoder.sv
module boot_xlat_decoder
    import boot_xlat_pkg::*;
#(
    parameter int          NUM_WIN  = 8,
    parameter int          TGT_W    = 5,
    parameter int unsigned BOOT_TGT = 30,
    localparam int         IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xlat_we,
    input  logic             xlat_en_wr,
    input  logic [19:0]      xlat_page_wr,
    input  logic             win_we,
    input  logic [IDX_W-1:0] win_idx,
    input  logic             win_en_wr,
    input  logic [23:0]      win_base_wr,
    input  logic [5:0]       win_size_wr,
    input  logic [TGT_W-1:0] win_tgt_wr,
    input  logic             req_valid,
    input  logic [35:0]      req_addr,
    output logic             rsp_valid,
    output logic [35:0]      rsp_addr,
    output logic [TGT_W-1:0] rsp_tgt,
    output logic             rsp_miss
);

    typedef enum logic {RS_IDLE, RS_RESULT} rsp_state_e;

    rsp_state_e                     state_q, state_d;
    logic [PA_W-1:0]                xaddr;
    logic [NUM_WIN-1:0]             hit;
    logic [NUM_WIN-1:0][TGT_W-1:0]  win_tgt;
    logic [TGT_W-1:0]               sel_tgt;
    logic                           sel_miss;

    boot_page_remap u_remap (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (xlat_we),
        .en_wr    (xlat_en_wr),
        .page_wr  (xlat_page_wr),
        .addr_in  (req_addr),
        .addr_out (xaddr)
    );

    win_match_array #(.NUM_WIN(NUM_WIN), .TGT_W(TGT_W)) u_wins (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (win_we),
        .idx     (win_idx),
        .en_wr   (win_en_wr),
        .base_wr (win_base_wr),
        .size_wr (win_size_wr),
        .tgt_wr  (win_tgt_wr),
        .addr    (xaddr),
        .hit     (hit),
        .tgt     (win_tgt)
    );

    win_prio_sel #(.NUM_WIN(NUM_WIN), .TGT_W(TGT_W), .BOOT_TGT(BOOT_TGT)) u_sel (
        .hit      (hit),
        .tgt      (win_tgt),
        .addr     (xaddr),
        .sel_tgt  (sel_tgt),
        .sel_miss (sel_miss)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:   state_d = req_valid ? RS_RESULT : RS_IDLE;
            RS_RESULT: state_d = req_valid ? RS_RESULT : RS_IDLE;
            default:   state_d = RS_IDLE;
        endcase
    end

    // output process: capture the decode of each accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_addr <= '0;
            rsp_tgt  <= '0;
            rsp_miss <= 1'b0;
        end else if (req_valid) begin
            rsp_addr <= xaddr;
            rsp_tgt  <= sel_tgt;
            rsp_miss <= sel_miss;
        end
    end

    assign rsp_valid = (state_q == RS_RESULT);

endmodule

// File: rtl/boot_xlat_decoder_chk.sv
module boot_xlat_decoder_chk #(
    parameter int TGT_W = 5
)(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [35:0]      req_addr,
    input logic             rsp_valid,
    input logic [35:0]      rsp_addr,
    input logic [TGT_W-1:0] rsp_tgt,
    input logic             rsp_miss
);

    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_addr[11:0] == $past(req_addr[11:0]));

    a_r3_outside_page_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[35:12] != 24'h0F_FFFF) |=> rsp_addr == $past(req_addr));

    a_r9_miss_tgt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> rsp_tgt == '0);

    a_r4_bootwin_never_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_addr[35:23] == 13'h01FF) |-> !rsp_miss);

endmodule

bind boot_xlat_decoder boot_xlat_decoder_chk #(.TGT_W(TGT_W)) u_chk (.*);

// File: tb/test_boot_xlat_decoder.sv
module test_boot_xlat_decoder;

    localparam int NW   = 8;
    localparam int TW   = 5;
    localparam int BTGT = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xlat_we = 0, xlat_en_wr = 0;
    logic [19:0]   xlat_page_wr = '0;
    logic          win_we = 0, win_en_wr = 0;
    logic [2:0]    win_idx = '0;
    logic [23:0]   win_base_wr = '0;
    logic [5:0]    win_size_wr = '0;
    logic [TW-1:0] win_tgt_wr = '0;
    logic          req_valid = 0;
    logic [35:0]   req_addr = '0;
    logic          rsp_valid, rsp_miss;
    logic [35:0]   rsp_addr;
    logic [TW-1:0] rsp_tgt;

    int    n_checks = 0, n_fail = 0;
    bit    done = 0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    boot_xlat_decoder #(.NUM_WIN(NW), .TGT_W(TW), .BOOT_TGT(BTGT)) i_boot_xlat_decoder (.*);

    // ---------------- behavioural reference model ----------------
    bit          m_xen;
    logic [19:0] m_xpage;
    bit          m_en   [NW];
    logic [23:0] m_base [NW];
    int          m_sz   [NW];
    int          m_tgt  [NW];

    task automatic model_reset();
        m_xen = 0; m_xpage = '0;
        for (int i = 0; i < NW; i++) begin
            m_en[i] = 0; m_base[i] = '0; m_sz[i] = 12; m_tgt[i] = 0;
        end
    endtask

    task automatic predict(input logic [35:0] a, output logic [35:0] ta,
                           output int t, output bit miss);
        longint unsigned lo, hi, x;
        bit found = 0;
        ta = a;
        if (m_xen && a >= 36'h0_FFFF_F000 && a <= 36'h0_FFFF_FFFF)
            ta = {4'h0, m_xpage, a[11:0]};
        x = longint'(ta);
        t = 0; miss = 0;
        for (int i = 0; i < NW; i++) begin
            lo = (longint'({m_base[i], 12'h000}) / (64'd1 << m_sz[i])) * (64'd1 << m_sz[i]);
            hi = lo + (64'd1 << m_sz[i]);
            if (!found && m_en[i] && x >= lo && x < hi) begin
                found = 1; t = m_tgt[i];
            end
        end
        if (!found) begin
            if (x >= 64'hFF80_0000 && x <= 64'hFFFF_FFFF) t = BTGT;
            else miss = 1;
        end
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // compared on every clock
    always @(posedge clk) begin
        bit          e_valid;
        logic [35:0] e_addr;
        int          e_tgt;
        bit          e_miss;
        string       e_tag;
        e_valid = 0; e_addr = '0; e_tgt = 0; e_miss = 0; e_tag = cur_tag;
        if (!rst_n) begin
            model_reset();
        end else begin
            if (req_valid) begin
                e_valid = 1;
                predict(req_addr, e_addr, e_tgt, e_miss);
            end
            // writes become visible to the following request (R10)
            if (xlat_we) begin m_xen = xlat_en_wr; m_xpage = xlat_page_wr; end
            if (win_we) begin
                m_en[win_idx]   = win_en_wr;
                m_base[win_idx] = win_base_wr;
                m_sz[win_idx]   = (win_size_wr < 12) ? 12 : (win_size_wr > 32) ? 32 : int'(win_size_wr);
                m_tgt[win_idx]  = int'(win_tgt_wr);
            end
        end
        #2;
        if (rst_n) begin
            chk("R1", "rsp_valid", 36'(rsp_valid), 36'(e_valid));
            if (e_valid) begin
                chk(e_tag, "rsp_addr", rsp_addr, e_addr);
                chk(e_tag, "rsp_tgt",  36'(rsp_tgt), 36'(e_tgt));
                chk(e_tag, "rsp_miss", 36'(rsp_miss), 36'(e_miss));
            end
        end
    end

    // ---------------- drivers ----------------
    task automatic clear_all();
        xlat_we = 0; win_we = 0; req_valid = 0;
    endtask

    task automatic idle();
        @(negedge clk); clear_all();
    endtask

    task automatic do_req(input logic [35:0] a, input string tag);
        @(negedge clk); clear_all();
        req_valid = 1; req_addr = a; cur_tag = tag;
    endtask

    task automatic do_win(input int idx, input bit en, input logic [23:0] base,
                          input int sz, input int tgt);
        @(negedge clk); clear_all();
        win_we = 1; win_idx = 3'(idx); win_en_wr = en;
        win_base_wr = base; win_size_wr = 6'(sz); win_tgt_wr = TW'(tgt);
    endtask

    task automatic do_xlat(input bit en, input logic [19:0] page);
        @(negedge clk); clear_all();
        xlat_we = 1; xlat_en_wr = en; xlat_page_wr = page;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: response idle while and right after reset
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 rsp_valid in reset: actual %b expected 0", rsp_valid);
        end
        rst_n = 1;
        idle();
        // R11 / R2: nothing programmed, boot page maps to itself
        do_req(36'h0_FFFF_F123, "R11");
        do_req(36'h0_FFFF_FABC, "R2");
        do_req(36'h0_FF80_0000, "R4");
        do_req(36'h0_FFFF_FFFF, "R4");
        do_req(36'h0_FF7F_FFFF, "R9");
        do_req(36'h1_FFFF_F000, "R9");
        idle(); idle();
        // R10: remap write in the same cycle as a boot-page request
        @(negedge clk); clear_all();
        xlat_we = 1; xlat_en_wr = 1; xlat_page_wr = 20'h80000;
        req_valid = 1; req_addr = 36'h0_FFFF_F456; cur_tag = "R10";
        // R8: remapped page not covered anywhere -> miss
        do_req(36'h0_FFFF_FABC, "R8");
        do_req(36'h1_FFFF_F010, "R3");
        do_req(36'h0_FFFF_E000, "R3");
        // R5: 256MB window at 0x8000_0000
        do_win(0, 1, 24'h080000, 28, 3);
        do_req(36'h0_FFFF_F800, "R8");
        do_req(36'h0_8FFF_FFFF, "R5");
        do_req(36'h0_9000_0000, "R5");
        // R6: 1MB window inside the boot window
        do_win(2, 1, 24'h0FF800, 20, 7);
        do_req(36'h0_FF80_1000, "R6");
        do_req(36'h0_FF90_0000, "R4");
        // R7: overlapping window with unaligned base bits
        do_win(1, 1, 24'h080123, 16, 5);
        do_req(36'h0_8012_5000, "R7");
        do_req(36'h0_8011_FFFF, "R7");
        do_win(0, 0, 24'h080000, 28, 3);
        do_req(36'h0_8012_5000, "R7");
        do_req(36'h0_8012_0000, "R5");
        do_req(36'h0_8013_0000, "R9");
        // R5 extremes: 4GB and 4KB windows
        do_win(3, 1, 24'h000000, 32, 9);
        do_req(36'h0_1234_5678, "R5");
        do_req(36'h0_FFC0_0000, "R6");
        do_win(4, 1, 24'h300001, 12, 11);
        do_req(36'h3_0000_1FFF, "R5");
        do_req(36'h3_0000_2000, "R9");
        // R10: window enable in same cycle as request
        @(negedge clk); clear_all();
        win_we = 1; win_idx = 3'd5; win_en_wr = 1; win_base_wr = 24'h500000;
        win_size_wr = 6'd20; win_tgt_wr = 5'd13;
        req_valid = 1; req_addr = 36'h5_0000_0040; cur_tag = "R10";
        do_req(36'h5_0000_0040, "R10");
        // R2 after disabling remap: boot page back to itself
        do_xlat(0, 20'h12345);
        do_req(36'h0_FFFF_F00C, "R2");
        idle();
        do_req(36'h0_FF81_0000, "R6");
        idle(); idle();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule